// File: doc/BRIEF.md
# Match-Compare Operating-System Tick Timer

This block is a tick timer for an operating system, placed on a simple word-wide register port. It has one up-counter and one match register. While a compare is armed, the counter moves up by one on every cycle in which the tick-enable input is high. The tick-enable is expected to be a one-cycle pulse derived from a 50 MHz reference. When the counter reaches the match value, it stops there and the compare disarms. If interrupt enable was nonzero at that moment, a status flag is latched and a level interrupt is raised.

Software arms a compare by writing a new match value. It reads the current count at its own offset and sets the interrupt enable. It acknowledges an interrupt by writing zero to the status register. The counter wraps from all-ones to zero. A match value at or below the current count therefore fires only after that wrap. The counter width is a parameter, 32 bits by default, and the counter reads back zero-extended on the 32-bit data bus.

Top module: `os_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the match, count, status and interrupt-enable registers all read zero, the interrupt is low and no compare is armed, so ticks do not move the counter.
- R2: A write to offset 0x00 stores the low counter-width bits of the data as the match value (read back at 0x00) and arms the compare; a tick in that write cycle is not counted.
- R3: While armed, each cycle with tick-enable high increments the count, which reads at offset 0x10; the count wraps from all-ones to zero.
- R4: On the tick that brings the count to the match value, the count stays at the match value and the compare disarms; later ticks do not move it until the match register is written again.
- R5: The interrupt-enable register at 0x1c stores and reads back all 32 bits; if it was nonzero in the cycle of a match, the status register at 0x14 reads 1 afterwards.
- R6: If the interrupt-enable register was zero in the cycle of a match, that match sets neither the status flag nor the interrupt.
- R7: A write of zero to 0x14 clears the status flag and the interrupt; a write of any nonzero value to 0x14 is ignored.
- R8: The interrupt output is a level equal to the status flag: it stays high until the status is cleared.
- R9: Reads from unmapped offsets return zero; writes to 0x10 or to unmapped offsets change no register.
- R10: If a match with interrupt enable nonzero and a status-clear write fall in the same cycle, the status flag is set afterwards.
- R11: A match value not above the current count fires only after the counter wraps; a match value equal to the count needs 2^width ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count-enable pulse, one per counter step |
| bus_addr | input | 8 | Byte offset of the word being accessed |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that each bus write lasts exactly one cycle. They also assume that bus_addr, bus_we, bus_wdata and tick_en stay stable from the middle of one cycle to the next rising edge. The bench meets this by changing every input a quarter period after the rising edge and holding it through the following edge. The stimulus covers the difficult cases with directed sequences: a compare that needs a wrap, a match value equal to the count, and a match that falls in the same cycle as a status clear. A randomized phase then mixes ticks, writes to every mapped offset and writes to unmapped offsets.

// File: rtl/os_timer_pkg.sv
// Package: register offsets and widths shared by the timer modules.
// Assumes word-aligned byte offsets on an 8-bit address.
package os_timer_pkg;
    localparam int BUS_ADDR_W = 8;
    localparam int BUS_DATA_W = 32;

    localparam logic [BUS_ADDR_W-1:0] OFS_MATCH  = 8'h00;
    localparam logic [BUS_ADDR_W-1:0] OFS_COUNT  = 8'h10;
    localparam logic [BUS_ADDR_W-1:0] OFS_STATUS = 8'h14;
    localparam logic [BUS_ADDR_W-1:0] OFS_IRQEN  = 8'h1c;
endpackage

// File: rtl/ost_counter.sv
// Module: armed up-counter with a single equality compare.
// The counter moves only while armed. Loading a new match value arms it and
// drops the tick of that cycle. On reaching the match value the counter
// stops there and disarms. hit is a one-cycle combinational pulse.
module ost_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_match,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             armed_q;
    logic             step;

    // Decide whether this cycle advances the counter and whether it hits.
    always_comb begin
        step    = armed_q && tick_en && !load_match;
        cnt_nxt = cnt_q + 1'b1;
        hit     = step && (cnt_nxt == match_val);
    end

    // Counter and arm state; a load re-arms, a hit disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_match) begin
            armed_q <= 1'b1;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            if (hit) armed_q <= 1'b0;
        end
    end

    assign count = cnt_q;

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick_en && !load_match) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !load_match) |=> $stable(cnt_q));
    a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!armed_q && cnt_q == $past(match_val)));
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        load_match |=> (armed_q && $stable(cnt_q)));
endmodule

// File: rtl/ost_status.sv
// Module: status flag and level interrupt.
// Assumes hit is the one-cycle match pulse and irq_on reflects the enable
// register as it was before this edge. A match outranks a clear.
module ost_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_on,
    input  logic clear,
    output logic status,
    output logic irq
);
    logic status_q;
    logic raise;

    // A match only raises the flag when interrupts are enabled.
    always_comb raise = hit && irq_on;

    // Status flag: set by an enabled match, cleared by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= 1'b0;
        else if (raise)   status_q <= 1'b1;
        else if (clear)   status_q <= 1'b0;
    end

    assign status = status_q;
    assign irq    = status_q;

    a_r10_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && irq_on && clear) |=> status_q);
    a_r6_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q && !(hit && irq_on)) |=> !status_q);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && clear && !hit) |=> !status_q);
    a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !clear) |=> status_q);
endmodule

// File: rtl/ost_regs.sv
// Module: register decode, match and interrupt-enable storage, read mux.
// Assumes full-word accesses at word-aligned offsets. Any other offset
// reads zero and ignores writes.
module ost_regs
    import os_timer_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              status,
    output logic              load_match,
    output logic [CNT_W-1:0]  match_val,
    output logic              irq_on,
    output logic              clear,
    output logic [DATA_W-1:0] rdata
);
    logic [CNT_W-1:0]  match_q;
    logic [DATA_W-1:0] irqen_q;
    logic sel_match, sel_count, sel_status, sel_irqen;

    // Address decode of the mapped offsets.
    always_comb begin
        sel_match  = (addr == ADDR_W'(OFS_MATCH));
        sel_count  = (addr == ADDR_W'(OFS_COUNT));
        sel_status = (addr == ADDR_W'(OFS_STATUS));
        sel_irqen  = (addr == ADDR_W'(OFS_IRQEN));
        load_match = we && sel_match;
        clear      = we && sel_status && (wdata == '0);
    end

    // Match and interrupt-enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            irqen_q <= '0;
        end else begin
            if (load_match)       match_q <= wdata[CNT_W-1:0];
            if (we && sel_irqen)  irqen_q <= wdata;
        end
    end

    assign match_val = match_q;
    assign irq_on    = |irqen_q;

    // Read mux; narrow fields are zero-extended.
    always_comb begin
        rdata = '0;
        if (sel_match)       rdata[CNT_W-1:0] = match_q;
        else if (sel_count)  rdata[CNT_W-1:0] = count;
        else if (sel_status) rdata[0]         = status;
        else if (sel_irqen)  rdata            = irqen_q;
    end

    a_r5_irqen_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_irqen) |=> (irqen_q == $past(wdata)));
    a_r9_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (sel_match || sel_irqen)) |=> ($stable(match_q) && $stable(irqen_q)));
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_match || sel_count || sel_status || sel_irqen) |-> (rdata == '0));
endmodule

// File: rtl/os_tick_timer.sv
// Module: top of the match-compare tick timer.
// Ties the register block, the armed counter and the status flag together.
// Assumes CNT_W <= DATA_W and tick_en pulses for one cycle per step.
module os_tick_timer
    import os_timer_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             load_match;
    logic [CNT_W-1:0] match_val;
    logic [CNT_W-1:0] count;
    logic             hit;
    logic             irq_on;
    logic             clear;
    logic             status;

    ost_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .count(count), .status(status),
        .load_match(load_match), .match_val(match_val),
        .irq_on(irq_on), .clear(clear), .rdata(bus_rdata)
    );

    ost_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .load_match(load_match), .match_val(match_val),
        .count(count), .hit(hit)
    );

    ost_status u_status (
        .clk(clk), .rst_n(rst_n), .hit(hit), .irq_on(irq_on),
        .clear(clear), .status(status), .irq(irq)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq && count == '0));
endmodule

// File: tb/test_os_tick_timer.sv
module test_os_tick_timer;
    localparam int CW   = 8;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int          m_cnt, m_mat, m_st;
    bit          m_arm, seen;
    logic [31:0] m_ie;

    always #10 clk = ~clk;

    os_tick_timer #(.CNT_W(CW)) i_os_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model updated on each rising edge
    always @(posedge clk) begin
        bit ev;
        if (!rst_n) begin
            m_cnt = 0; m_mat = 0; m_st = 0; m_arm = 0; m_ie = '0;
        end else begin
            ev = 0;
            if (bus_we && bus_addr == 8'h00) begin
                m_mat = int'(bus_wdata) & MASK;
                m_arm = 1;
            end else if (m_arm && tick_en) begin
                m_cnt = (m_cnt + 1) & MASK;
                if (m_cnt == m_mat) begin
                    m_arm = 0;
                    ev = (m_ie != 0);
                end
            end
            if (ev) m_st = 1;
            else if (bus_we && bus_addr == 8'h14 && bus_wdata == 0) m_st = 0;
            if (bus_we && bus_addr == 8'h1c) m_ie = bus_wdata;
        end
        seen = 1;
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h00:   return 32'(m_mat);
            8'h10:   return 32'(m_cnt);
            8'h14:   return 32'(m_st);
            8'h1c:   return m_ie;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R2";
            8'h10:   return "R3";
            8'h14:   return "R5";
            8'h1c:   return "R5";
            default: return "R9";
        endcase
    endfunction

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (seen && rst_n && !done) begin
            chk(bus_rdata == model_rd(bus_addr), tag_of(bus_addr), bus_rdata, model_rd(bus_addr));
            chk(irq == (m_st != 0), "R8", 32'(irq), 32'(m_st));
        end
    end

    // tasks start a quarter period after a rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #5;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk); #5;
        end
        tick_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1: reset state and a stopped counter
        rd_chk(8'h00, 0, "R1"); rd_chk(8'h10, 0, "R1");
        rd_chk(8'h14, 0, "R1"); rd_chk(8'h1c, 0, "R1");
        chk(irq == 1'b0, "R1", 32'(irq), 0);
        tk(4);
        rd_chk(8'h10, 0, "R1");

        // R2/R3/R5: enabled match after five ticks; the write cycle tick is dropped
        wr(8'h1c, 32'hA5A5_0001);
        rd_chk(8'h1c, 32'hA5A5_0001, "R5");
        tick_en = 1'b1;
        wr(8'h00, 32'hFFFF_FF05);
        tick_en = 1'b0;
        rd_chk(8'h00, 32'h05, "R2");
        rd_chk(8'h10, 0, "R2");
        tk(4);
        rd_chk(8'h14, 0, "R5");
        tk(1);
        rd_chk(8'h10, 5, "R3");
        rd_chk(8'h14, 1, "R5");
        chk(irq == 1'b1, "R8", 32'(irq), 1);
        // R4: count holds after the match
        tk(3);
        rd_chk(8'h10, 5, "R4");

        // R7: nonzero write ignored, zero write clears
        wr(8'h14, 32'h7);
        rd_chk(8'h14, 1, "R7");
        wr(8'h14, 32'h0);
        rd_chk(8'h14, 0, "R7");
        chk(irq == 1'b0, "R7", 32'(irq), 0);

        // R6: match with enable zero raises nothing
        wr(8'h1c, 32'h0);
        wr(8'h00, 32'd10);
        tk(5);
        rd_chk(8'h10, 10, "R6");
        rd_chk(8'h14, 0, "R6");
        chk(irq == 1'b0, "R6", 32'(irq), 0);

        // R9: stray writes and unmapped reads
        wr(8'h10, 32'h55); wr(8'h04, 32'hFFFF_FFFF); wr(8'h1d, 32'h1);
        rd_chk(8'h10, 10, "R9");
        rd_chk(8'h00, 10, "R9");
        rd_chk(8'h1c, 0, "R9");
        rd_chk(8'h08, 0, "R9");
        rd_chk(8'h18, 0, "R9");

        // R11: match below count needs a wrap
        wr(8'h1c, 32'h1);
        wr(8'h00, 32'd3);
        tk(248);
        rd_chk(8'h10, 2, "R11");
        rd_chk(8'h14, 0, "R11");
        tk(1);
        rd_chk(8'h10, 3, "R11");
        rd_chk(8'h14, 1, "R11");
        wr(8'h14, 32'h0);
        // R11: match equal to count needs a full turn
        wr(8'h00, 32'd3);
        tk(255);
        rd_chk(8'h10, 2, "R11");
        rd_chk(8'h14, 0, "R11");
        tk(1);
        rd_chk(8'h14, 1, "R11");

        // R10: match and clear in the same cycle
        wr(8'h00, 32'd5);
        tk(1);
        tick_en = 1'b1;
        wr(8'h14, 32'h0);
        tick_en = 1'b0;
        rd_chk(8'h10, 5, "R10");
        rd_chk(8'h14, 1, "R10");
        chk(irq == 1'b1, "R10", 32'(irq), 1);
        wr(8'h14, 32'h0);

        // randomized mix checked by the per-cycle model compare
        for (int c = 0; c < 4000; c++) begin
            int r;
            logic [7:0] ra;
            r = int'($urandom_range(0, 31));
            ra = 8'($urandom_range(0, 31));
            tick_en = ($urandom_range(0, 3) != 0);
            bus_addr = ra;
            if (r == 0)      begin bus_we = 1; bus_addr = 8'h00; bus_wdata = $urandom; end
            else if (r == 1) begin bus_we = 1; bus_addr = 8'h1c; bus_wdata = 32'($urandom_range(0, 1)); end
            else if (r == 2) begin bus_we = 1; bus_addr = 8'h14; bus_wdata = 32'($urandom_range(0, 1)); end
            else if (r == 3) begin bus_we = 1; bus_wdata = $urandom; end
            @(posedge clk); #5;
            bus_we = 0; bus_wdata = '0;
        end
        tick_en = 0;

        @(posedge clk); #5;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule